// File: doc/BRIEF.md
# Half-Rate Dual-Lane PRBS Generator

This block produces a pseudo-random bit sequence at two bits per clock. The state is held as two interleaved shift registers (lanes) that run on a single clock. One lane holds the even-numbered bits of the sequence and the other holds the odd-numbered bits. Each lane's next bit is formed from taps that are spread across both lanes. Together the lanes advance the full-rate sequence by two positions on every edge. A downstream 2:1 serializer can send lane 0 first and then lane 1 to rebuild the full-rate stream, and it needs no clock of its own.

A static mode input selects between the long polynomial x^31 + x^28 + 1 (period 2^31-1) and the short polynomial x^7 + x^6 + 1 (period 127). A cleared register set can never leave the all-zero state by itself. A starter therefore watches the active part of the state and, when it finds it all zero, writes ones into the first stage of both lanes on the next clock. A change of mode clears the whole state synchronously. The starter then reseeds it in the new length, so no mixed-length state is ever emitted.

Top module: `prbs_halfrate`

## Requirements
- R1: While `rst` is high, and on the first sample after a clock edge with `rst` high, `valid_o` is 0 and `word_o` is 2'b00.
- R2: On the first clock edge after reset release or after a reseed, `valid_o` rises and `word_o` is 2'b11 (starter ones on both lanes).
- R3: In long mode (`mode_short_i` = 0), the serial stream is formed by taking `word_o[0]` and then `word_o[1]` from each valid word in time order. Every bit of that stream equals the XOR of the bits 28 and 31 positions earlier. Positions before the starter word count as 0.
- R4: In short mode (`mode_short_i` = 1), every bit of the serial stream equals the XOR of the bits 6 and 7 positions earlier. Positions before the starter word count as 0.
- R5: In short mode the serial stream repeats with a period of exactly 127 bits, and each period holds 64 ones.
- R6: A change of `mode_short_i` seen at a clock edge drives `valid_o` low for exactly that one cycle. The new sequence then restarts under R2.
- R7: While `rst` is low and `mode_short_i` is unchanged, `valid_o` stays high once it has risen.
- R8: While `valid_o` is high, the serial stream never holds more than 30 consecutive zeros in long mode, or more than 6 in short mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-rate clock; one output word per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_short_i | input | 1 | 0 selects the 31-stage polynomial, 1 selects the 7-stage polynomial |
| word_o | output | 2 | Two sequence bits; bit 0 is the earlier one in the serial order |
| valid_o | output | 1 | High when `word_o` carries sequence bits |

## Verification
A corrupted stage or a wrong tap breaks the tap-XOR rule (R3, R4). In short mode this shows within one 7-bit window, which is four words. In long mode it shows within 31 bits, which is sixteen words. The bench rebuilds every expected bit from zero history, so it catches a wrong bit in the word in which it appears. Swapped lanes or a mis-ordered word break the rule at once. A starter that fails to fire, or a reseed that leaves mixed state, shows at the ports as a missing 2'b11 word or a missing one-cycle drop of `valid_o`.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    localparam int LANES      = 2;
    localparam int LONG_LEN   = 31;
    localparam int LONG_TAP   = 28;
    localparam int SHORT_LEN  = 7;
    localparam int SHORT_TAP  = 6;
    localparam int LANE_DEPTH = (LONG_LEN + LANES - 1) / LANES;
    localparam int HIST_W     = LANE_DEPTH * LANES;

    typedef enum logic {
        MODE_LONG  = 1'b0,
        MODE_SHORT = 1'b1
    } prbs_mode_e;

    typedef logic [LANE_DEPTH-1:0] lane_t;
    typedef logic [HIST_W-1:0]     hist_t;

    typedef struct packed {
        logic second;   // later bit, goes to lane 1
        logic first;    // earlier bit, goes to lane 0
    } lane_pair_t;

    // Rebuild the full-rate history: bit 0 is the newest bit.
    function automatic hist_t interleave(lane_t l0, lane_t l1);
        hist_t h;
        for (int j = 0; j < LANE_DEPTH; j++) begin
            h[2*j]   = l1[j];
            h[2*j+1] = l0[j];
        end
        return h;
    endfunction

    function automatic int seq_len(prbs_mode_e m);
        return (m == MODE_SHORT) ? SHORT_LEN : LONG_LEN;
    endfunction

    function automatic int seq_tap(prbs_mode_e m);
        return (m == MODE_SHORT) ? SHORT_TAP : LONG_TAP;
    endfunction

    function automatic hist_t active_mask(prbs_mode_e m);
        hist_t msk = '0;
        for (int k = 0; k < HIST_W; k++)
            msk[k] = (k < seq_len(m));
        return msk;
    endfunction

    // Two steps of s[n] = s[n-tap] ^ s[n-len]; both come from the old history.
    function automatic lane_pair_t next_pair(hist_t h, prbs_mode_e m);
        lane_pair_t p;
        int len = seq_len(m);
        int tap = seq_tap(m);
        p.first  = h[tap-1] ^ h[len-1];
        p.second = h[tap-2] ^ h[len-2];
        return p;
    endfunction

endpackage

// File: rtl/prbs_lane.sv
module prbs_lane #(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             din,
    output logic [DEPTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (clr) q <= '0;
        else     q <= {q[DEPTH-2:0], din};
    end
endmodule

// File: rtl/prbs_feedback.sv
module prbs_feedback
    import prbs_pkg::*;
(
    input  hist_t      hist,
    input  prbs_mode_e mode,
    output lane_pair_t nxt,
    output logic       zero
);
    lane_pair_t fb;

    always_comb begin
        zero = ((hist & active_mask(mode)) == '0);
        fb   = next_pair(hist, mode);
        // starter: an all-zero window would lock up, so inject ones
        nxt  = zero ? lane_pair_t'(2'b11) : fb;
    end
endmodule

// File: rtl/prbs_seq_ctl.sv
module prbs_seq_ctl
    import prbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  prbs_mode_e mode_i,
    output prbs_mode_e mode_q,
    output logic       clear,
    output logic       valid_q
);
    assign clear = rst || (mode_i != mode_q);

    always_ff @(posedge clk) begin
        mode_q  <= mode_i;
        valid_q <= !clear;
    end

    AST_RESEED_DROP: assert property (@(posedge clk) disable iff (rst)
        (mode_i != mode_q) |=> !valid_q); // R6
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (valid_q && mode_i == mode_q) |=> valid_q); // R7
endmodule

// File: rtl/prbs_halfrate.sv
module prbs_halfrate
    import prbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_short_i,
    output logic [1:0] word_o,
    output logic       valid_o
);
    prbs_mode_e mode_q;
    logic       clear;
    logic       zero;
    lane_pair_t nxt;
    hist_t      hist;
    lane_t      lane_q   [LANES];
    logic       lane_din [LANES];

    prbs_seq_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .mode_i  (prbs_mode_e'(mode_short_i)),
        .mode_q  (mode_q),
        .clear   (clear),
        .valid_q (valid_o)
    );

    assign hist = interleave(lane_q[0], lane_q[1]);

    prbs_feedback u_fb (
        .hist (hist),
        .mode (mode_q),
        .nxt  (nxt),
        .zero (zero)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_din[g] = (g == 0) ? nxt.first : nxt.second;
        prbs_lane #(.DEPTH(LANE_DEPTH)) u_lane (
            .clk (clk),
            .clr (clear),
            .din (lane_din[g]),
            .q   (lane_q[g])
        );
    end

    assign word_o = {lane_q[1][0], lane_q[0][0]};

    AST_START_ONES: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> (word_o == 2'b11)); // R2
    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> !zero); // R8
endmodule

// File: tb/prbs_halfrate_bench.sv
module prbs_halfrate_bench;
    logic       clk = 0;
    logic       rst = 1;
    logic       mode_short_i = 0;
    logic [1:0] word_o;
    logic       valid_o;

    int tests = 0, fails = 0;
    logic       cur_mode = 0;
    logic [63:0] bh = '0;
    int nbits = 0, zrun = 0;
    logic sb [0:511];
    int sn = 0;
    bit cap_en = 0;

    always #5 clk = ~clk;

    prbs_halfrate u_prbs_halfrate (
        .clk(clk), .rst(rst), .mode_short_i(mode_short_i),
        .word_o(word_o), .valid_o(valid_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic model_bit(logic m);
        if (nbits < 2) return 1'b1;
        return m ? (bh[5] ^ bh[6]) : (bh[27] ^ bh[30]);
    endfunction

    task automatic model_clear();
        bh = '0; nbits = 0; zrun = 0;
    endtask

    task automatic run_cycle(input logic m);
        logic chg;
        logic [1:0] ew;
        string tag;
        chg = (m != cur_mode);
        mode_short_i = m;
        cur_mode = m;
        @(posedge clk); #2;
        if (chg) begin
            chk(valid_o == 1'b0, "R6", valid_o, 0);
            model_clear();
        end else begin
            chk(valid_o == 1'b1, "R7", valid_o, 1);
            tag = (nbits == 0) ? "R2" : (m ? "R4" : "R3");
            for (int b = 0; b < 2; b++) begin
                ew[b] = model_bit(m);
                bh = {bh[62:0], ew[b]};
                nbits++;
            end
            chk(word_o == ew, tag, word_o, ew);
            for (int b = 0; b < 2; b++) begin
                zrun = word_o[b] ? 0 : zrun + 1;
                if (cap_en && sn < 512) begin sb[sn] = word_o[b]; sn++; end
            end
            chk(zrun <= (m ? 6 : 30), "R8", zrun, m ? 6 : 30);
        end
    endtask

    task automatic do_reset(input logic m);
        rst = 1; mode_short_i = m; cur_mode = m;
        repeat (2) @(posedge clk);
        #2;
        chk(valid_o == 1'b0, "R1", valid_o, 0);
        chk(word_o == 2'b00, "R1", word_o, 0);
        rst = 0;
        model_clear();
    endtask

    initial begin
        #2_000_000;
        fails++; tests++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int ones;
        void'($urandom(32'h5EED_1234));
        do_reset(1'b0);
        // directed long run: R2 on first word, then R3 recurrence
        repeat (300) run_cycle(1'b0);
        // directed switch to short mode, capture for the period check
        run_cycle(1'b1);
        cap_en = 1; sn = 0;
        repeat (200) run_cycle(1'b1);
        cap_en = 0;
        // R5: period 127 and 64 ones per period
        for (int n = 127; n < 400; n++)
            chk(sb[n] == sb[n-127], "R5", sb[n], sb[n-127]);
        ones = 0;
        for (int n = 0; n < 127; n++) ones += sb[n];
        chk(ones == 64, "R5", ones, 64);
        for (int p = 1; p < 127; p++) begin
            bit same = 1;
            for (int n = 0; n < 127; n++)
                if (sb[n+p] != sb[n]) same = 0;
            chk(!same, "R5", p, 127);
        end
        // mid-run reset in short mode
        do_reset(1'b1);
        repeat (20) run_cycle(1'b1);
        // random mode segments
        for (int s = 0; s < 12; s++) begin
            logic m = 1'($urandom % 2);
            int len = 1 + ($urandom % 150);
            repeat (len) run_cycle(m);
        end
        // back-to-back mode toggles
        for (int s = 0; s < 6; s++) run_cycle(s[0]);
        repeat (10) run_cycle(1'b1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule